// File: doc/BRIEF.md
# Complementary Mosaic Luma/Chroma Separator

This block sits behind the digitiser of a CCD that carries a yellow, cyan, magenta and green mosaic. The sensor already mixes two vertically neighbouring pixels, so each incoming sample is a pixel-pair sum. On one kind of line the samples alternate between (G+Cy) and (Mg+Ye). On the other kind they alternate between (Mg+Cy) and (G+Ye). The block groups the samples of a line into horizontal pairs. For each pair it produces one luminance value and one colour-difference value.

Luminance is half the sum of the two samples. It approximates (2B+3G+2R)/2 on both line kinds. Chroma is the second sample of the pair minus the first. On lines of the first kind this gives (Mg+Ye)-(G+Cy), which approximates R-Y. On lines of the second kind it gives (G+Ye)-(Mg+Cy), which approximates -(B-Y). The two colour differences therefore alternate from line to line, and the same rule holds in both fields.

The chroma output carries a tag that repeats the line-parity bit captured at the start of the line. A later stage can use this tag to delay one line and recombine both colour differences. Filtering, colour matrixing and encoding belong to other stages.

Top module: `mosaic_yc_split`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `y_valid`, `y_out`, `c_out` and `c_tag` are all zero.
- R2: Accepted samples (`in_valid` high) are grouped in pairs. `y_valid` pulses high for exactly one cycle, on the cycle after the second sample of each pair is accepted. It is never high on two consecutive cycles.
- R3: For a pair (a then b), `y_out` equals floor((a+b)/2) at IN_W bits. For example, with IN_W=10, 1023 and 1023 give 1023, and 5 and 8 give 6.
- R4: For a pair (a then b), `c_out` equals b-a as an IN_W+1 bit two's-complement number. With IN_W=10 the result spans -1023 to +1023.
- R5: `c_tag` equals the value `line_odd` had on the accepted sample that carried `line_start`. Value 0 marks R-Y and value 1 marks -(B-Y). A change of `line_odd` in the middle of a line does not change the tag.
- R6: A cycle with `in_valid` low is ignored. The pairing phase is kept, and the next cycle has `y_valid` low.
- R7: An accepted sample with `line_start` high always becomes the first sample of a new pair, and it yields no output on the next cycle. A lone first sample left over from the previous line is discarded.
- R8: On every cycle with `y_valid` low, `y_out`, `c_out` and `c_tag` keep their previous values.
- R9: `line_start` has no effect when `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample qualifier |
| in_data | input | IN_W | Pixel-pair sum sample, unsigned |
| line_start | input | 1 | Marks the first sample of a line (taken only with `in_valid`) |
| line_odd | input | 1 | Line parity, captured at line start |
| y_valid | output | 1 | One-cycle pulse: new luminance and chroma |
| y_out | output | IN_W | Luminance, truncated half sum |
| c_out | output | IN_W+1 | Signed colour difference, second minus first |
| c_tag | output | 1 | 0 = R-Y, 1 = -(B-Y) |

## Verification
Every result is due one clock after the second sample of its pair is presented. The first sample of a pair is held in a register, and the result register loads on the edge that accepts the second sample. The bench drives inputs on falling edges. After the second sample it waits exactly one falling edge and samples the outputs there. After a first sample, a gap cycle or a restart, it samples at the same offset to confirm that `y_valid` stayed low and that the held values did not move.

// File: rtl/mosaic_yc_pkg.sv
package mosaic_yc_pkg;
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } pair_phase_e;

  localparam logic TAG_R_MINUS_Y = 1'b0;
  localparam logic TAG_NEG_B_MINUS_Y = 1'b1;
endpackage

// File: rtl/myc_pair_track.sv
module myc_pair_track
  import mosaic_yc_pkg::*;
#(
  parameter int IN_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_data,
  input  logic            line_start,
  input  logic            line_odd,
  output logic            pair_done,
  output logic [IN_W-1:0] first_q,
  output logic            tag_q
);
  pair_phase_e phase_q;
  logic        restart;

  assign restart   = in_valid && line_start;
  assign pair_done = in_valid && !line_start && (phase_q == PH_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FIRST;
      first_q <= '0;
      tag_q   <= TAG_R_MINUS_Y;
    end else if (restart) begin
      phase_q <= PH_SECOND;
      first_q <= in_data;
      tag_q   <= line_odd;
    end else if (in_valid) begin
      if (phase_q == PH_FIRST) begin
        phase_q <= PH_SECOND;
        first_q <= in_data;
      end else begin
        phase_q <= PH_FIRST;
      end
    end
  end

  // R5: the parity tag moves only at an accepted line start
  assert_tag_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !restart |=> $stable(tag_q));

  // R7: a line start always opens a fresh pair
  assert_restart_phase_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase_q == PH_SECOND));

  // R6: an idle cycle keeps the pairing phase
  assert_idle_phase_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase_q));
endmodule

// File: rtl/myc_pair_math.sv
module myc_pair_math #(
  parameter int IN_W = 10
) (
  input  logic [IN_W-1:0]   smp_a,
  input  logic [IN_W-1:0]   smp_b,
  output logic [IN_W-1:0]   luma,
  output logic signed [IN_W:0] chroma
);
  localparam int SUM_W = IN_W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum    = {1'b0, smp_a} + {1'b0, smp_b};
    luma   = sum[SUM_W-1:1];
    chroma = $signed({1'b0, smp_b}) - $signed({1'b0, smp_a});
  end
endmodule

// File: rtl/myc_out_stage.sv
module myc_out_stage #(
  parameter int IN_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [IN_W-1:0]      luma,
  input  logic signed [IN_W:0] chroma,
  input  logic                 tag,
  output logic                 vld_q,
  output logic [IN_W-1:0]      luma_q,
  output logic signed [IN_W:0] chroma_q,
  output logic                 tag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= 1'b0;
      luma_q   <= '0;
      chroma_q <= '0;
      tag_q    <= 1'b0;
    end else begin
      vld_q <= load;
      if (load) begin
        luma_q   <= luma;
        chroma_q <= chroma;
        tag_q    <= tag;
      end
    end
  end
endmodule

// File: rtl/mosaic_yc_split.sv
module mosaic_yc_split #(
  parameter int IN_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [IN_W-1:0]      in_data,
  input  logic                 line_start,
  input  logic                 line_odd,
  output logic                 y_valid,
  output logic [IN_W-1:0]      y_out,
  output logic signed [IN_W:0] c_out,
  output logic                 c_tag
);
  logic                 pair_done;
  logic [IN_W-1:0]      first_q;
  logic                 line_tag;
  logic [IN_W-1:0]      luma;
  logic signed [IN_W:0] chroma;

  myc_pair_track #(.IN_W(IN_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .line_start (line_start),
    .line_odd   (line_odd),
    .pair_done  (pair_done),
    .first_q    (first_q),
    .tag_q      (line_tag)
  );

  myc_pair_math #(.IN_W(IN_W)) u_math (
    .smp_a  (first_q),
    .smp_b  (in_data),
    .luma   (luma),
    .chroma (chroma)
  );

  myc_out_stage #(.IN_W(IN_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (pair_done),
    .luma     (luma),
    .chroma   (chroma),
    .tag      (line_tag),
    .vld_q    (y_valid),
    .luma_q   (y_out),
    .chroma_q (c_out),
    .tag_q    (c_tag)
  );

  // R2: one output per pair, never back to back
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    y_valid |=> !y_valid);

  // R6: no output after an idle input cycle
  assert_idle_no_out_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !y_valid);

  // R7: the opening sample of a line never completes a pair
  assert_start_no_out_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && line_start) |=> !y_valid);

  // R8: held results do not move between pulses
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !y_valid |-> ($stable(y_out) && $stable(c_out) && $stable(c_tag)));
endmodule

// File: tb/mosaic_yc_split_tb.sv
module mosaic_yc_split_tb;
  localparam int IN_W = 10;
  localparam time CLK_PERIOD = 10ns;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic [IN_W-1:0]      in_data = '0;
  logic                 line_start = 1'b0;
  logic                 line_odd = 1'b0;
  logic                 y_valid;
  logic [IN_W-1:0]      y_out;
  logic signed [IN_W:0] c_out;
  logic                 c_tag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mosaic_yc_split #(.IN_W(IN_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .line_start(line_start), .line_odd(line_odd),
    .y_valid(y_valid), .y_out(y_out), .c_out(c_out), .c_tag(c_tag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int d, input bit ls, input bit odd);
    @(negedge clk);
    in_valid = 1'b1; in_data = d[IN_W-1:0]; line_start = ls; line_odd = odd;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; line_start = 1'b0;
  endtask

  // Sends a, b and checks the result one edge after b is taken.
  task automatic pair_check(input string req, input int a, input int b,
                            input bit ls, input bit odd, input int exp_tag);
    drive(a, ls, odd);
    drive(b, 1'b0, odd);
    chk({req, " no out after first"}, int'(y_valid), 0);
    idle();
    chk({req, " valid"}, int'(y_valid), 1);
    chk({req, " R3 luma"}, int'(y_out), (a + b) / 2);
    chk({req, " R4 chroma"}, int'(c_out), b - a);
    chk({req, " R5 tag"}, int'(c_tag), exp_tag);
  endtask

  task automatic t_reset_R1();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid", int'(y_valid), 0);
    chk("R1 y", int'(y_out), 0);
    chk("R1 c", int'(c_out), 0);
    chk("R1 tag", int'(c_tag), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle valid", int'(y_valid), 0);
  endtask

  task automatic t_line_types_R2();
    pair_check("R2 typeA", 200, 340, 1'b1, 1'b0, 0);
    pair_check("R2 typeA next", 5, 8, 1'b0, 1'b0, 0);
    pair_check("R2 typeB", 410, 150, 1'b1, 1'b1, 1);
    pair_check("R2 typeB next", 77, 78, 1'b0, 1'b1, 1);
  endtask

  task automatic t_extremes_R3_R4();
    pair_check("R3 max", 1023, 1023, 1'b1, 1'b0, 0);
    pair_check("R4 most negative", 1023, 0, 1'b0, 1'b0, 0);
    pair_check("R4 most positive", 0, 1023, 1'b0, 1'b0, 0);
  endtask

  task automatic t_parity_mid_line_R5();
    pair_check("R5 open", 10, 20, 1'b1, 1'b1, 1);
    pair_check("R5 flip ignored", 30, 12, 1'b0, 1'b0, 1);
  endtask

  task automatic t_gap_R6();
    drive(100, 1'b1, 1'b0);
    idle();
    chk("R6 no out in gap", int'(y_valid), 0);
    idle();
    chk("R6 no out in gap 2", int'(y_valid), 0);
    drive(300, 1'b0, 1'b0);
    idle();
    chk("R6 valid after gap", int'(y_valid), 1);
    chk("R6 luma after gap", int'(y_out), 200);
    chk("R6 chroma after gap", int'(c_out), 200);
  endtask

  task automatic t_restart_R7();
    drive(900, 1'b1, 1'b0);
    drive(50, 1'b1, 1'b1);
    idle();
    chk("R7 no out on restart", int'(y_valid), 0);
    drive(60, 1'b0, 1'b1);
    idle();
    chk("R7 valid", int'(y_valid), 1);
    chk("R7 luma uses restart sample", int'(y_out), 55);
    chk("R7 chroma", int'(c_out), 10);
    chk("R7 tag", int'(c_tag), 1);
  endtask

  task automatic t_hold_R8();
    pair_check("R8 load", 400, 100, 1'b1, 1'b0, 0);
    drive(7, 1'b0, 1'b1);
    chk("R8 valid low", int'(y_valid), 0);
    chk("R8 y held", int'(y_out), 250);
    chk("R8 c held", int'(c_out), -300);
    idle();
    chk("R8 tag held", int'(c_tag), 0);
    idle();
    chk("R8 y still held", int'(y_out), 250);
  endtask

  task automatic t_start_needs_valid_R9();
    drive(40, 1'b1, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; line_start = 1'b1; line_odd = 1'b1;
    drive(44, 1'b0, 1'b0);
    idle();
    chk("R9 pair kept", int'(y_valid), 1);
    chk("R9 luma", int'(y_out), 42);
    chk("R9 tag unchanged", int'(c_tag), 0);
  endtask

  initial begin
    fork
      begin
        t_reset_R1();
        t_line_types_R2();
        t_extremes_R3_R4();
        t_parity_mid_line_R5();
        t_gap_R6();
        t_restart_R7();
        t_hold_R8();
        t_start_needs_valid_R9();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_bad++;
          $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule